// File: doc/BRIEF.md
# Optical Link Laser Safety Handshake Controller

This block keeps the laser of an optical serial link eye-safe. It tracks whether light is arriving from the far end, using a DC and an AC loss-of-light flag. It decides when the local laser may shine and when the transceiver must loop back internally. After power-on reset the link is parked with the laser dark and loopback engaged. Software must issue a strobed control write with the loopback-enable input high before the controller starts probing the fibre with short laser pulses. Those pulses repeat once every long repetition period until the far end answers with light, and then the link becomes fully active.

All timing comes from outside the block. A 13 MHz clock enable paces every sampling decision. Two decode pulses from an external timer mark the end of the short pulse/wait window and the end of the long repetition period. The same repetition decode is used whatever the link rate. A laser-disable input from an external clock checker overrides everything and forces the laser off within one clock, without disturbing the handshake state.

Top module: `ofc_safety_ctrl`

## Requirements
- R1: After reset, `link_state` is Stop (2'd2), `laser_en` is 0 and `loopback_en` is 1. The other state codes are Active 2'd0, Disconnect 2'd1 and Reconnect 2'd3.
- R2: In Stop, a write taken with `cs_rw`=1 and `loop_en`=1 moves to Reconnect in its lit phase: `laser_en`=1 and `loopback_en`=0. A write is taken at a tick where `cs_strobe` is first seen high.
- R3: A strobe rising edge with `cs_rw`=0 leaves state and outputs unchanged. A strobe that stays high is taken only once.
- R4: A write with `cs_rw`=1 and `loop_en`=0 returns to Stop from any state (`laser_en`=0, `loopback_en`=1). In Stop, loss-of-light flags and decode pulses have no effect. `loopback_en` is 1 exactly in Stop.
- R5: In the lit phase of Reconnect, `dec_short` at a tick moves to Active with the laser kept on if both loss flags are 0. If either flag is 1, the laser goes off and the controller stays in Reconnect, dark phase.
- R6: In the dark phase of Reconnect, `dec_rep` at a tick starts a new lit pulse (`laser_en`=1), and `dec_short` is ignored.
- R7: In Active, either loss flag high at a tick moves to Disconnect with `laser_en`=0.
- R8: In Disconnect, `dec_short` at a tick moves to Reconnect, dark phase. `dec_rep` is ignored there.
- R9: Inputs take effect only on clock edges where `tick_en`=1. On other edges the state does not change.
- R10: While `clk_fault`=1, `laser_en` is 0 from the next clock edge on, whatever `tick_en` is, and the state is kept. When the fault clears, the laser resumes at the next edge.
- R11: A write command at a tick takes priority over loss-of-light and decode events at the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_en | input | 1 | 13 MHz sampling enable |
| los_dc | input | 1 | DC loss-of-light flag, 1 = no light |
| los_ac | input | 1 | AC loss-of-light flag, 1 = no light |
| dec_short | input | 1 | Short-window decode pulse from timer |
| dec_rep | input | 1 | Repetition-period decode pulse from timer |
| clk_fault | input | 1 | Clock-checker laser-disable override |
| cs_strobe | input | 1 | Control write strobe |
| cs_rw | input | 1 | 1 = write cycle |
| loop_en | input | 1 | Loopback-enable data for a write (1 = start link) |
| laser_en | output | 1 | Registered laser enable |
| loopback_en | output | 1 | Internal loopback control |
| link_state | output | 2 | Current handshake state code |

## Verification
The assertions take for granted that every input is synchronous to `clk` and settles before the edge where it is sampled. They also assume that decode pulses and strobe edges matter only on enabled edges. The bench therefore changes inputs only on falling edges and raises `tick_en` for single isolated cycles. It holds the strobe high across one tick and releases it across the next, so the edge detector sees a clean rise. Loss flags and decode pulses are also applied without `tick_en`, to show they are ignored until an enabled edge arrives.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_DISC   = 2'd1,
        ST_STOP   = 2'd2,
        ST_RECON  = 2'd3
    } link_st_e;

    typedef struct packed {
        link_st_e st;
        logic     lit;
    } hs_regs_t;

    localparam int unsigned STATE_W = $bits(link_st_e);

endpackage

// File: rtl/ofc_strobe_cap.sv
module ofc_strobe_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic cs_strobe,
    input  logic cs_rw,
    input  logic loop_en,
    output logic cmd_start,
    output logic cmd_stop
);
    logic strb_d, strb_q;
    logic rise;

    always_comb begin
        strb_d    = tick_en ? cs_strobe : strb_q;
        rise      = tick_en & cs_strobe & ~strb_q;
        cmd_start = rise & cs_rw & loop_en;
        cmd_stop  = rise & cs_rw & ~loop_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strb_d;
    end

    // R3: a held strobe yields at most one command
    a_r3_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start | cmd_stop) |=> !(cmd_start | cmd_stop));

endmodule

// File: rtl/ofc_hs_fsm.sv
module ofc_hs_fsm
    import ofc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               los_dc,
    input  logic               los_ac,
    input  logic               dec_short,
    input  logic               dec_rep,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    output logic               laser_req,
    output logic               loop_q,
    output logic [STATE_W-1:0] st_code
);
    hs_regs_t r_d, r_q;
    logic     dark;

    always_comb begin
        dark = los_dc | los_ac;
        r_d  = r_q;
        if (tick_en) begin
            if (cmd_stop) begin
                r_d.st  = ST_STOP;
                r_d.lit = 1'b0;
            end else if (cmd_start && r_q.st == ST_STOP) begin
                r_d.st  = ST_RECON;
                r_d.lit = 1'b1;
            end else if (!cmd_start) begin
                unique case (r_q.st)
                    ST_ACTIVE: begin
                        if (dark) begin
                            r_d.st  = ST_DISC;
                            r_d.lit = 1'b0;
                        end
                    end
                    ST_DISC: begin
                        if (dec_short) begin
                            r_d.st  = ST_RECON;
                            r_d.lit = 1'b0;
                        end
                    end
                    ST_RECON: begin
                        if (r_q.lit) begin
                            if (dec_short) begin
                                r_d.lit = 1'b0;
                                if (!dark) r_d.st = ST_ACTIVE;
                            end
                        end else if (dec_rep) begin
                            r_d.lit = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
        laser_req = (r_d.st == ST_ACTIVE) || (r_d.st == ST_RECON && r_d.lit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_STOP;
            r_q.lit <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign loop_q  = (r_q.st == ST_STOP);
    assign st_code = r_q.st;

    // R9: no movement without the sampling enable
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(r_q));
    // R4: stop command always lands in Stop
    a_r4_stop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cmd_stop) |=> (r_q.st == ST_STOP));
    // R2: start command from Stop enters lit Reconnect
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cmd_start && r_q.st == ST_STOP) |=> (r_q.st == ST_RECON && r_q.lit));
    // R7: light lost while active drops to Disconnect
    a_r7_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cmd_stop && !cmd_start && r_q.st == ST_ACTIVE && (los_dc || los_ac))
        |=> (r_q.st == ST_DISC));

endmodule

// File: rtl/ofc_laser_drv.sv
module ofc_laser_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic laser_req,
    input  logic clk_fault,
    output logic laser_q
);
    logic laser_d;

    always_comb laser_d = laser_req & ~clk_fault;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) laser_q <= 1'b0;
        else        laser_q <= laser_d;
    end

    // R10: fault forces the laser dark on the next edge
    a_r10_fault_dark: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fault |=> !laser_q);

endmodule

// File: rtl/ofc_safety_ctrl.sv
module ofc_safety_ctrl
    import ofc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               los_dc,
    input  logic               los_ac,
    input  logic               dec_short,
    input  logic               dec_rep,
    input  logic               clk_fault,
    input  logic               cs_strobe,
    input  logic               cs_rw,
    input  logic               loop_en,
    output logic               laser_en,
    output logic               loopback_en,
    output logic [STATE_W-1:0] link_state
);
    logic cmd_start, cmd_stop, laser_req;

    ofc_strobe_cap u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cs_strobe (cs_strobe),
        .cs_rw     (cs_rw),
        .loop_en   (loop_en),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop)
    );

    ofc_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .los_dc    (los_dc),
        .los_ac    (los_ac),
        .dec_short (dec_short),
        .dec_rep   (dec_rep),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .laser_req (laser_req),
        .loop_q    (loopback_en),
        .st_code   (link_state)
    );

    ofc_laser_drv u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .laser_req (laser_req),
        .clk_fault (clk_fault),
        .laser_q   (laser_en)
    );

    // R4: loopback and laser are never both on
    a_r4_loop_dark: assert property (@(posedge clk) disable iff (!rst_n)
        loopback_en |-> !laser_en);

endmodule

// File: tb/ofc_safety_ctrl_tb.sv
module ofc_safety_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 0, los_dc = 0, los_ac = 0, dec_short = 0, dec_rep = 0;
    logic clk_fault = 0, cs_strobe = 0, cs_rw = 0, loop_en = 0;
    logic laser_en, loopback_en;
    logic [1:0] link_state;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] st;
        logic       las;
        logic       lb;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    event chk_ev;

    localparam logic [1:0] S_ACT = 2'd0, S_DIS = 2'd1, S_STP = 2'd2, S_REC = 2'd3;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofc_safety_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .los_dc(los_dc), .los_ac(los_ac),
        .dec_short(dec_short), .dec_rep(dec_rep), .clk_fault(clk_fault),
        .cs_strobe(cs_strobe), .cs_rw(cs_rw), .loop_en(loop_en),
        .laser_en(laser_en), .loopback_en(loopback_en), .link_state(link_state)
    );

    // monitor: compares queued expectations against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (link_state !== e.st || laser_en !== e.las || loopback_en !== e.lb) begin
                    n_fail++;
                    $display("FAIL %s: got st=%0d laser=%0b loop=%0b, expected st=%0d laser=%0b loop=%0b",
                             e.tag, link_state, laser_en, loopback_en, e.st, e.las, e.lb);
                end
            end
        end
    end

    task automatic expect_out(input logic [1:0] st, input logic las, input logic lb, input string tag);
        exp_t e;
        e.st = st; e.las = las; e.lb = lb; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // one enabled edge, then back to a falling edge for sampling
    task automatic tick();
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_cmd(input logic rw, input logic le);
        cs_strobe = 1'b1; cs_rw = rw; loop_en = le;
        tick();
    endtask

    task automatic release_strobe();
        cs_strobe = 1'b0; cs_rw = 1'b0; loop_en = 1'b0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(S_STP, 0, 1, "R1 reset state");

        // Stop ignores loss and decodes (R4)
        los_ac = 1; dec_short = 1; dec_rep = 1;
        tick();
        los_ac = 0; dec_short = 0; dec_rep = 0;
        expect_out(S_STP, 0, 1, "R4 stop ignores events");

        // read strobe does nothing (R3)
        write_cmd(0, 1);
        expect_out(S_STP, 0, 1, "R3 read strobe ignored");
        release_strobe();

        // start strobe held without enable (R9)
        cs_strobe = 1; cs_rw = 1; loop_en = 1;
        idle(3);
        expect_out(S_STP, 0, 1, "R9 no enable no change");
        tick();
        expect_out(S_REC, 1, 0, "R2 start enters lit reconnect");
        tick();
        expect_out(S_REC, 1, 0, "R3 held strobe taken once");
        release_strobe();

        // lit pulse ends without light (R5)
        los_ac = 1; dec_short = 1;
        tick();
        dec_short = 0;
        expect_out(S_REC, 0, 0, "R5 no light -> dark");
        dec_short = 1;
        tick();
        dec_short = 0; los_ac = 0;
        expect_out(S_REC, 0, 0, "R6 short ignored in dark");
        dec_rep = 1;
        tick();
        dec_rep = 0;
        expect_out(S_REC, 1, 0, "R6 repetition relights");
        dec_short = 1;
        tick();
        dec_short = 0;
        expect_out(S_ACT, 1, 0, "R5 light -> active");

        // fault override (R10)
        clk_fault = 1;
        idle(1);
        expect_out(S_ACT, 0, 0, "R10 fault forces dark");
        clk_fault = 0;
        idle(1);
        expect_out(S_ACT, 1, 0, "R10 laser resumes");

        // loss without enable then with (R9, R7)
        los_dc = 1;
        idle(2);
        expect_out(S_ACT, 1, 0, "R9 loss waits for tick");
        tick();
        los_dc = 0;
        expect_out(S_DIS, 0, 0, "R7 dc loss -> disconnect");

        dec_rep = 1;
        tick();
        dec_rep = 0;
        expect_out(S_DIS, 0, 0, "R8 rep ignored in disconnect");
        dec_short = 1;
        tick();
        dec_short = 0;
        expect_out(S_REC, 0, 0, "R8 short -> dark reconnect");
        dec_rep = 1;
        tick();
        dec_rep = 0;
        dec_short = 1;
        tick();
        dec_short = 0;
        expect_out(S_ACT, 1, 0, "R5 second link up");

        // ac loss from active (R7)
        los_ac = 1;
        tick();
        los_ac = 0;
        expect_out(S_DIS, 0, 0, "R7 ac loss -> disconnect");
        dec_short = 1; tick(); dec_short = 0;
        dec_rep = 1; tick(); dec_rep = 0;
        dec_short = 1; tick(); dec_short = 0;
        expect_out(S_ACT, 1, 0, "R5 third link up");

        // stop write together with loss (R11, R4)
        los_ac = 1;
        write_cmd(1, 0);
        los_ac = 0;
        expect_out(S_STP, 0, 1, "R11 write wins over loss");
        release_strobe();

        // stop from reconnect (R4)
        write_cmd(1, 1);
        release_strobe();
        expect_out(S_REC, 1, 0, "R2 restart");
        dec_short = 1;
        write_cmd(1, 0);
        dec_short = 0;
        expect_out(S_STP, 0, 1, "R4 stop from reconnect");
        release_strobe();

        idle(2);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule